// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital controller of a 16-bit successive-approximation analog-to-digital converter with a serial result port. A host raises the SAMPLE line to let the analog array track the input. It drops SAMPLE to freeze that input, then supplies clock pulses. The controller walks a trial code from the most significant bit down to the least, asking the comparator one question per pulse. Each decided bit leaves at once on a serial data line, next to a data clock derived from the master clock. A conversion takes exactly seventeen clock pulses. The first commits the sample and the remaining sixteen decide one bit each.

A separate CAL line resets the controller at once, without waiting for a clock edge, and starts calibration. While CAL is high the controller holds BUSY high. When CAL falls, the controller runs a fixed count of clock edges that stands in for the calibration routine. During that count the data clock keeps pulsing and SAMPLE selects what the data line shows. When BUSY drops, calibration is over. The analog array, the calibration arithmetic and the correction memory lie outside this block.

States: `ST_IDLE` (waiting, SAMPLE low), `ST_ACQUIRE` (SAMPLE high, input tracking), `ST_CONVERT` (bit search and shift-out), `ST_CAL_HOLD` (CAL high, or first edge after it falls), `ST_CAL_RUN` (counted calibration). Transitions: IDLE→ACQUIRE when SAMPLE is high. ACQUIRE→CONVERT ("commit") on an edge that sees SAMPLE low. CONVERT→ACQUIRE or CONVERT→IDLE after the last bit, depending on SAMPLE. CAL high sends any state to CAL_HOLD asynchronously. CAL_HOLD→CAL_RUN on the first edge after CAL falls. CAL_RUN→ACQUIRE or CAL_RUN→IDLE after the last calibration edge, depending on SAMPLE.

Top module: `sar_seq_ctrl`

## Requirements
- R1: In ACQUIRE, a rising CLK edge that sees SAMPLE low commits a conversion. After that edge BUSY is high and the trial code on `dac_code_o` is 0x8000, that is, only bit 15 is set.
- R2: A conversion spans exactly 17 rising CLK edges, counting the commit edge as the first. BUSY is high after edges 1 to 16 and low after edge 17.
- R3: Bits are decided from bit 15 down to bit 0, one per edge, on edges 2 to 17. A bit stays set when `cmp_i` is high (input at or above the trial level) and is cleared otherwise, and the next lower bit is set as the new trial. After edge 17, `dac_code_o` equals the offset-binary input code.
- R4: After edge k of a conversion (k = 2..17), `dout_o` carries bit 17−k of the two's-complement result, which is the offset-binary result with bit 15 inverted. The MSB therefore sits under the second data-clock pulse and the LSB under the seventeenth. `dout_clk_o` is high during the low phase of CLK after every valid edge.
- R5: SAMPLE changes during a conversion do not alter its length or its result.
- R6: With BUSY low and no commit, CLK edges change nothing. `dout_o` and `dac_code_o` hold their values, `dout_clk_o` stays low, and `cmp_i` has no effect.
- R7: If SAMPLE is high at the edge where BUSY falls, the next edge that sees SAMPLE low commits a new conversion. If SAMPLE is low at that edge, no conversion starts until SAMPLE rises and falls again.
- R8: CAL high at once, with no clock edge, drives BUSY high, aborts a conversion, clears `dout_o`, `dout_clk_o` and `dac_code_o`, and keeps them so while CAL stays high.
- R9: After CAL falls, BUSY stays high through edges 1 to CAL_CYCLES−1 and is low after edge CAL_CYCLES. `dout_clk_o` pulses after each of those edges.
- R10: During calibration, SAMPLE high forces `dout_o` to 0 after each edge. With SAMPLE low, `dout_o` after edge k is (k−1) mod 2, the low bit of the calibration counter.
- R11: While `rst_ni` is low, BUSY, `dout_o`, `dout_clk_o` and `dac_code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; only edges during a conversion or calibration are acted on |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sample_i | input | 1 | Acquisition control; falling into a clock edge commits a conversion, selects debug output during calibration |
| cal_i | input | 1 | Calibration request, active high, asynchronous hard reset |
| cmp_i | input | 1 | Comparator decision: 1 when the held input is at or above the trial level |
| dac_code_o | output | DATA_W | Trial code driven to the capacitor DAC, offset binary |
| busy_o | output | 1 | High during a conversion or calibration |
| dout_o | output | 1 | Serial result, two's complement, MSB first |
| dout_clk_o | output | 1 | Data clock, high in the CLK low phase after each valid edge |

## Verification
The hardest situation to reach is a CAL pulse that lands between clock edges in the middle of a bit search. This is where the asynchronous clear has to win over the running state, blank a data-clock pulse already in progress, and reset the trial code. The stimulus starts a conversion, lets five bits resolve, and raises CAL in the low phase of the clock. It then samples one nanosecond later, before any edge. From there it holds CAL for four cycles and runs a short calibration with SAMPLE high. That run leaves the controller in acquisition, so the dummy conversion that follows also exercises the re-arm path.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ACQUIRE  = 3'd1,
        ST_CONVERT  = 3'd2,
        ST_CAL_HOLD = 3'd3,
        ST_CAL_RUN  = 3'd4
    } seq_state_e;

    function automatic logic state_is_busy(seq_state_e s);
        return (s == ST_CONVERT) || (s == ST_CAL_HOLD) || (s == ST_CAL_RUN);
    endfunction

endpackage

// File: rtl/sar_seq_fsm.sv
`timescale 1ns/1ps
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CAL_CYCLES = 4096,
    localparam int PTR_W     = $clog2(DATA_W),
    localparam int CNT_W     = $clog2(CAL_CYCLES + 1)
) (
    input  logic             clk_i,
    input  logic             hard_clr_i,
    input  logic             cal_i,
    input  logic             sample_i,
    output logic             busy_o,
    output logic             commit_o,
    output logic             decide_o,
    output logic             cal_step_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             diag_o
);

    localparam logic [PTR_W-1:0] TOP_PTR  = PTR_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CAL_LAST = CNT_W'(CAL_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] cal_cnt_q;
    logic             last_bit;
    logic             cal_done;

    assign last_bit = (ptr_q == '0);
    assign cal_done = (cal_cnt_q == CAL_LAST);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (sample_i)  state_d = ST_ACQUIRE;
            ST_ACQUIRE:  if (!sample_i) state_d = ST_CONVERT;
            ST_CONVERT:  if (last_bit)  state_d = sample_i ? ST_ACQUIRE : ST_IDLE;
            ST_CAL_HOLD:                state_d = ST_CAL_RUN;
            ST_CAL_RUN:  if (cal_done)  state_d = sample_i ? ST_ACQUIRE : ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state register with the hard clear
    always_ff @(posedge clk_i or posedge hard_clr_i) begin
        if (hard_clr_i) begin
            state_q <= cal_i ? ST_CAL_HOLD : ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // bit pointer and calibration counter
    always_ff @(posedge clk_i or posedge hard_clr_i) begin
        if (hard_clr_i) begin
            ptr_q     <= '0;
            cal_cnt_q <= '0;
        end else begin
            if (commit_o) begin
                ptr_q <= TOP_PTR;
            end else if (decide_o && !last_bit) begin
                ptr_q <= ptr_q - 1'b1;
            end
            if (state_q == ST_CAL_HOLD) begin
                cal_cnt_q <= CNT_W'(1);
            end else if (state_q == ST_CAL_RUN) begin
                cal_cnt_q <= cal_done ? '0 : cal_cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o     = state_is_busy(state_q);
        commit_o   = (state_q == ST_ACQUIRE) && !sample_i;
        decide_o   = (state_q == ST_CONVERT);
        cal_step_o = (state_q == ST_CAL_HOLD) || (state_q == ST_CAL_RUN);
        ptr_o      = ptr_q;
        diag_o     = cal_cnt_q[0];
    end

    // R2: the pointer walks down by one on every non-final search edge
    p_ptr_walk_r2: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        (state_q == ST_CONVERT && !last_bit) |=> (state_q == ST_CONVERT && ptr_q == PTR_W'($past(ptr_q) - 1'b1)));

    // R5: SAMPLE cannot end a search early
    p_sample_blind_r5: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        (state_q == ST_CONVERT && !last_bit && !sample_i) |=> busy_o);

    // R7: SAMPLE high at the last search edge re-arms acquisition
    p_rearm_r7: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        (state_q == ST_CONVERT && last_bit && sample_i) |=> (state_q == ST_ACQUIRE));

    // R9: calibration counter advances by one each edge until done
    p_cal_len_r9: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        (state_q == ST_CAL_RUN && !cal_done) |=> (state_q == ST_CAL_RUN && cal_cnt_q == CNT_W'($past(cal_cnt_q) + 1'b1)));

endmodule

// File: rtl/sar_seq_search.sv
`timescale 1ns/1ps
module sar_seq_search #(
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DATA_W)
) (
    input  logic              clk_i,
    input  logic              hard_clr_i,
    input  logic              commit_i,
    input  logic              decide_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] code_o
);

    logic [DATA_W-1:0] code_q;
    logic [DATA_W-1:0] code_d;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == DATA_W - 1) begin : g_top
            assign code_d[i] = commit_i ? 1'b1 :
                               (decide_i && ptr_i == PTR_W'(i)) ? cmp_i : code_q[i];
        end else begin : g_low
            assign code_d[i] = commit_i ? 1'b0 :
                               (decide_i && ptr_i == PTR_W'(i))     ? cmp_i :
                               (decide_i && ptr_i == PTR_W'(i + 1)) ? 1'b1  : code_q[i];
        end
    end

    always_ff @(posedge clk_i or posedge hard_clr_i) begin
        if (hard_clr_i) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code_o = code_q;

    // R1: a commit presents the top bit alone as the first trial
    p_commit_msb_r1: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        commit_i |=> (code_q == {1'b1, {(DATA_W-1){1'b0}}}));

    // R3: the decided bit takes the comparator answer
    p_keep_r3: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        decide_i |=> (code_q[$past(ptr_i)] == $past(cmp_i)));

    // R6: with no commit and no search step the code is frozen
    p_code_hold_r6: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        (!commit_i && !decide_i) |=> $stable(code_q));

endmodule

// File: rtl/sar_seq_serial.sv
`timescale 1ns/1ps
module sar_seq_serial #(
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DATA_W)
) (
    input  logic             clk_i,
    input  logic             hard_clr_i,
    input  logic             commit_i,
    input  logic             decide_i,
    input  logic             cal_step_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic             cmp_i,
    input  logic             sample_i,
    input  logic             diag_i,
    output logic             dout_o,
    output logic             dout_clk_o
);

    localparam logic [PTR_W-1:0] TOP_PTR = PTR_W'(DATA_W - 1);

    logic dout_q, dout_d;
    logic pulse_q, pulse_d;

    always_comb begin
        pulse_d = commit_i || decide_i || cal_step_i;
        dout_d  = dout_q;
        if (decide_i) begin
            dout_d = (ptr_i == TOP_PTR) ? ~cmp_i : cmp_i;
        end else if (cal_step_i) begin
            dout_d = sample_i ? 1'b0 : diag_i;
        end
    end

    always_ff @(posedge clk_i or posedge hard_clr_i) begin
        if (hard_clr_i) begin
            dout_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            dout_q  <= dout_d;
            pulse_q <= pulse_d;
        end
    end

    assign dout_o     = dout_q;
    assign dout_clk_o = pulse_q & ~clk_i;

    // R4: the sign bit leaves inverted from the offset-binary decision
    p_sign_r4: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        (decide_i && ptr_i == TOP_PTR) |=> (dout_q == !$past(cmp_i)));

    // R6: ignored edges neither move the data line nor make a clock pulse
    p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        (!commit_i && !decide_i && !cal_step_i) |=> ($stable(dout_q) && !pulse_q));

    // R10: SAMPLE high during calibration keeps the data line low
    p_cal_quiet_r10: assert property (@(posedge clk_i) disable iff (hard_clr_i)
        (cal_step_i && sample_i) |=> !dout_q);

endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl #(
    parameter int DATA_W     = 16,
    parameter int CAL_CYCLES = 4096
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sample_i,
    input  logic              cal_i,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] dac_code_o,
    output logic              busy_o,
    output logic              dout_o,
    output logic              dout_clk_o
);

    localparam int PTR_W = $clog2(DATA_W);

    logic             hard_clr;
    logic             commit;
    logic             decide;
    logic             cal_step;
    logic [PTR_W-1:0] ptr;
    logic             diag;

    assign hard_clr = cal_i | ~rst_ni;

    sar_seq_fsm #(
        .DATA_W     (DATA_W),
        .CAL_CYCLES (CAL_CYCLES)
    ) u_fsm (
        .clk_i      (clk_i),
        .hard_clr_i (hard_clr),
        .cal_i      (cal_i),
        .sample_i   (sample_i),
        .busy_o     (busy_o),
        .commit_o   (commit),
        .decide_o   (decide),
        .cal_step_o (cal_step),
        .ptr_o      (ptr),
        .diag_o     (diag)
    );

    sar_seq_search #(
        .DATA_W (DATA_W)
    ) u_search (
        .clk_i      (clk_i),
        .hard_clr_i (hard_clr),
        .commit_i   (commit),
        .decide_i   (decide),
        .ptr_i      (ptr),
        .cmp_i      (cmp_i),
        .code_o     (dac_code_o)
    );

    sar_seq_serial #(
        .DATA_W (DATA_W)
    ) u_serial (
        .clk_i      (clk_i),
        .hard_clr_i (hard_clr),
        .commit_i   (commit),
        .decide_i   (decide),
        .cal_step_i (cal_step),
        .ptr_i      (ptr),
        .cmp_i      (cmp_i),
        .sample_i   (sample_i),
        .diag_i     (diag),
        .dout_o     (dout_o),
        .dout_clk_o (dout_clk_o)
    );

endmodule

// File: tb/sar_seq_ctrl_bench.sv
`timescale 1ns/1ps
module sar_seq_ctrl_bench;

    localparam int W    = 16;
    localparam int CALN = 20;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sample;
    logic         cal;
    logic         cmp;
    logic [W-1:0] in_val;
    logic [W-1:0] dac_code;
    logic         busy;
    logic         dout;
    logic         dout_clk;

    int vectors = 0;
    int misses  = 0;

    always #4 clk = ~clk;

    // comparator model: input at or above the trial level
    assign cmp = (in_val >= dac_code);

    sar_seq_ctrl #(.DATA_W(W), .CAL_CYCLES(CALN)) u_sar_seq_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sample_i   (sample),
        .cal_i      (cal),
        .cmp_i      (cmp),
        .dac_code_o (dac_code),
        .busy_o     (busy),
        .dout_o     (dout),
        .dout_clk_o (dout_clk)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one rising edge, then settle in the low phase
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    // a full conversion; noisy toggles SAMPLE, hold_hi leaves it high at the end
    task automatic t_convert(input logic [W-1:0] x, input bit noisy, input bit hold_hi, input bit pre_armed);
        logic [W-1:0] tc;
        tc     = x ^ {1'b1, {(W-1){1'b0}}};
        in_val = x;
        if (!pre_armed) begin
            sample = 1'b1;
            tick();
        end
        sample = 1'b0;
        tick();
        chk(pre_armed ? "R7" : "R1", "busy after commit", int'(busy), 1);
        chk("R1", "first trial code", int'(dac_code), 32'h8000);
        chk("R4", "data clock pulse 1", int'(dout_clk), 1);
        for (int k = 2; k <= 17; k++) begin
            if (noisy) sample = k[0];
            if (hold_hi && k >= 10) sample = 1'b1;
            tick();
            chk(noisy ? "R5" : "R4", "serial bit", int'(dout), int'(tc[17-k]));
            chk("R4", "data clock pulse", int'(dout_clk), 1);
            chk("R2", "busy during search", int'(busy), (k < 17) ? 1 : 0);
        end
        chk(noisy ? "R5" : "R3", "final code", int'(dac_code), int'(x));
    endtask

    task automatic t_reset();
        chk("R11", "busy in reset", int'(busy), 0);
        chk("R11", "dout in reset", int'(dout), 0);
        chk("R11", "data clock in reset", int'(dout_clk), 0);
        chk("R11", "code in reset", int'(dac_code), 0);
    endtask

    task automatic t_idle_hold(input logic [W-1:0] x);
        logic d0;
        d0     = dout;
        in_val = ~x;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R6", "busy idle", int'(busy), 0);
            chk("R6", "data clock idle", int'(dout_clk), 0);
            chk("R6", "dout idle", int'(dout), int'(d0));
            chk("R6", "code idle", int'(dac_code), int'(x));
        end
    endtask

    task automatic t_no_rearm();
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R7", "no conversion without new sample", int'(busy), 0);
        end
    endtask

    task automatic t_cal_abort();
        in_val = 16'h4321;
        sample = 1'b1;
        tick();
        sample = 1'b0;
        tick();
        for (int i = 0; i < 5; i++) tick();
        cal = 1'b1;
        #1;
        chk("R8", "busy forced", int'(busy), 1);
        chk("R8", "dout cleared", int'(dout), 0);
        chk("R8", "data clock cleared", int'(dout_clk), 0);
        chk("R8", "code cleared", int'(dac_code), 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R8", "busy held", int'(busy), 1);
            chk("R8", "data clock quiet", int'(dout_clk), 0);
        end
    endtask

    task automatic t_cal_run(input logic lvl);
        sample = lvl;
        cal    = 1'b0;
        for (int k = 1; k <= CALN; k++) begin
            tick();
            chk("R9", "cal data clock", int'(dout_clk), 1);
            chk("R10", "cal dout", int'(dout), lvl ? 0 : ((k - 1) & 1));
            chk("R9", "cal busy", int'(busy), (k < CALN) ? 1 : 0);
        end
        tick();
        chk("R9", "busy after cal", int'(busy), 0);
        chk("R9", "data clock after cal", int'(dout_clk), 0);
    endtask

    initial begin
        #(200000 * 8);
        misses++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n  = 1'b0;
        cal    = 1'b0;
        sample = 1'b0;
        in_val = '0;
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_convert(16'h0000, 0, 0, 0);
        t_convert(16'hFFFF, 0, 0, 0);
        t_convert(16'h8000, 0, 0, 0);
        t_convert(16'h7FFF, 0, 0, 0);
        t_convert(16'h1234, 0, 0, 0);
        t_convert(16'hA5C3, 0, 0, 0);
        t_idle_hold(16'hA5C3);
        t_convert(16'h3C0F, 0, 1, 0);
        t_convert(16'hC001, 0, 0, 1);
        t_no_rearm();
        t_convert(16'h5AA5, 1, 0, 0);
        t_cal_abort();
        t_cal_run(1'b1);
        t_convert(16'h0001, 0, 0, 1);
        cal = 1'b1;
        repeat (4) tick();
        t_cal_run(1'b0);
        t_convert(16'hFFFE, 0, 0, 0);
        finish_run();
    end

endmodule